// File: doc/BRIEF.md
# Converter Configuration and Result DMA Link

This block joins a converter sequencer to two DMA channels. On the transmit channel it asks for configuration words and collects the settings for the next conversion. The top bit of each word tells the block whether a window-compare word must follow. Once the set is complete, it issues a one-cycle start-of-conversion pulse. It then waits for the sequencer to report that the conversion is done before it asks for the next set.

On the receive channel it holds the latest conversion result in a last-value register. It presents the result zero-extended to a 16-bit read and requests a transfer while the value is unread. If a new result arrives before the old one was read, a sticky overrun flag is set. Software clears the flag by writing a one to its bit in a clear register.

The transmit controller has four named states:
- `ST_IDLE` waits for a main word. A word with top bit 0 goes to `ST_START`; a word with top bit 1 goes to `ST_WIN`.
- `ST_WIN` waits for the window word. A word with top bit 0 goes to `ST_START`; a word with top bit 1 keeps the block in `ST_WIN`.
- `ST_START` issues the pulse and always moves to `ST_CONV`.
- `ST_CONV` waits for `conv_done` and then returns to `ST_IDLE`.

Top module: `adc_dma_link`

## Requirements
- R1: After reset, `tx_req`=1, `soc`=0, `rx_req`=0, `ovr`=0, `rx_data`=0 and `win_en`=0.
- R2: In `ST_IDLE`, a word with bit 31 = 0 is stored in `cfg_main` and clears `win_en`. `soc` is then high for exactly the one cycle that follows the accepting edge.
- R3: In `ST_IDLE`, a word with bit 31 = 1 is stored in `cfg_main` and no `soc` follows. A later word with bit 31 = 0 is stored in `cfg_win` and sets `win_en`, and `soc` is high in the following cycle.
- R4: In `ST_WIN`, a word with bit 31 = 1 is ignored: `cfg_main`, `cfg_win` and `tx_req` are unchanged and no `soc` follows.
- R5: `tx_req` is high in `ST_IDLE` and `ST_WIN`. It is low from the `soc` cycle until the cycle after `conv_done`. Words offered while `tx_req` is low are ignored.
- R6: `conv_done` loads `conv_result` into the result register. From the next cycle, `rx_data` shows it zero-extended to 16 bits and `rx_req` is 1.
- R7: `rx_rd` while `rx_req` is 1 (without `conv_done`) clears `rx_req` in the next cycle. `rx_rd` while `rx_req` is 0 changes nothing.
- R8: `conv_done` while `rx_req` is 1 and `rx_rd` is 0 sets `ovr`. `ovr` stays 1 until cleared.
- R9: `clr_wr` with `clr_data[1]`=1 clears `ovr`, and other bits of `clr_data` have no effect. If a set and a clear fall in the same cycle, `ovr` ends up 1.
- R10: `conv_done` and `rx_rd` in the same cycle do not set `ovr`. `rx_req` stays 1 and `rx_data` shows the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit DMA writes a configuration word |
| tx_data | input | 32 | Configuration word; bit 31 marks that a window word follows |
| tx_req | output | 1 | Block can accept a configuration word |
| soc | output | 1 | One-cycle start-of-conversion pulse |
| cfg_main | output | 32 | Main configuration word |
| cfg_win | output | 32 | Window configuration word |
| win_en | output | 1 | Current set includes a window word |
| conv_done | input | 1 | Sequencer finished a conversion |
| conv_result | input | 12 | Conversion result |
| rx_req | output | 1 | Unread result held |
| rx_rd | input | 1 | Receive DMA reads the result |
| rx_data | output | 16 | Result, zero-extended |
| ovr | output | 1 | Sticky overrun flag |
| clr_wr | input | 1 | Write strobe of the clear register |
| clr_data | input | 8 | Clear register data; bit 1 clears the overrun flag |

## Verification
Three kinds of configuration stream are tried: single words, main-plus-window pairs, and pairs interrupted by a stray word with the top bit set. These separate correct sequencing from a controller that counts words or trusts any word in `ST_WIN`. Words are also offered while the request is low, which exposes a controller that accepts writes during a conversion. On the result side, the bench drives results with and without pending reads, reads and results in the same cycle, and clears that land together with a set. These show whether overrun detection respects read timing and the set-over-clear priority. A long stretch of pseudo-random traffic is then compared with a behavioural model on every cycle.

// File: rtl/adc_dma_link_pkg.sv
package adc_dma_link_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WIN   = 2'd1,
        ST_START = 2'd2,
        ST_CONV  = 2'd3
    } cfg_st_e;
endpackage

// File: rtl/adc_cfg_fsm.sv
module adc_cfg_fsm
    import adc_dma_link_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid,
    input  logic [CFG_W-1:0] tx_data,
    input  logic             conv_done,
    output logic             tx_req,
    output logic             soc,
    output logic [CFG_W-1:0] cfg_main,
    output logic [CFG_W-1:0] cfg_win,
    output logic             win_en
);
    localparam int MARK = CFG_W - 1;

    cfg_st_e state, state_nx;
    logic    take;
    logic    mark;

    assign take = tx_valid && tx_req;
    assign mark = tx_data[MARK];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take) state_nx = mark ? ST_WIN : ST_START;
            ST_WIN:   if (take && !mark) state_nx = ST_START;
            ST_START: state_nx = ST_CONV;
            ST_CONV:  if (conv_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_req = 1'b0;
        soc    = 1'b0;
        unique case (state)
            ST_IDLE, ST_WIN: tx_req = 1'b1;
            ST_START:        soc    = 1'b1;
            default:         ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_main <= '0;
            cfg_win  <= '0;
            win_en   <= 1'b0;
        end else if (take) begin
            if (state == ST_IDLE) begin
                cfg_main <= tx_data;
                if (!mark) win_en <= 1'b0;
            end else if (state == ST_WIN && !mark) begin
                cfg_win <= tx_data;
                win_en  <= 1'b1;
            end
        end
    end

    // R2
    soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soc |=> !soc);
    // R5
    ignore_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_req) |=> ($stable(cfg_main) && $stable(cfg_win)));
    // R4
    stray_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIN && tx_valid && mark) |=> ($stable(cfg_main) && tx_req && !soc));
endmodule

// File: rtl/adc_res_reg.sv
module adc_res_reg #(
    parameter int RES_W   = 12,
    parameter int RD_W    = 16,
    parameter int CLR_W   = 8,
    parameter int OVR_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             rx_rd,
    input  logic             clr_wr,
    input  logic [CLR_W-1:0] clr_data,
    output logic             rx_req,
    output logic [RD_W-1:0]  rx_data,
    output logic             ovr
);
    logic [RES_W-1:0] last_q;
    logic             unread_q;
    logic             ovr_set, ovr_clr;

    assign ovr_set = conv_done && unread_q && !rx_rd;
    assign ovr_clr = clr_wr && clr_data[OVR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q   <= '0;
            unread_q <= 1'b0;
        end else if (conv_done) begin
            last_q   <= conv_result;
            unread_q <= 1'b1;
        end else if (rx_rd) begin
            unread_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (ovr_set) ovr <= 1'b1;
        else if (ovr_clr) ovr <= 1'b0;
    end

    assign rx_req = unread_q;

    generate
        if (RES_W < RD_W) begin : g_pad
            assign rx_data = {{(RD_W-RES_W){1'b0}}, last_q};
        end else begin : g_full
            assign rx_data = last_q[RD_W-1:0];
        end
    endgenerate

    // R6
    result_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> rx_req);
    // R7
    read_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_req && !conv_done) |=> !rx_req);
    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && rx_req && !rx_rd) |=> ovr);
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(clr_wr && clr_data[OVR_BIT])) |=> ovr);
endmodule

// File: rtl/adc_dma_link.sv
module adc_dma_link #(
    parameter int CFG_W   = 32,
    parameter int RES_W   = 12,
    parameter int RD_W    = 16,
    parameter int CLR_W   = 8,
    parameter int OVR_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid,
    input  logic [CFG_W-1:0] tx_data,
    output logic             tx_req,
    output logic             soc,
    output logic [CFG_W-1:0] cfg_main,
    output logic [CFG_W-1:0] cfg_win,
    output logic             win_en,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             rx_req,
    input  logic             rx_rd,
    output logic [RD_W-1:0]  rx_data,
    output logic             ovr,
    input  logic             clr_wr,
    input  logic [CLR_W-1:0] clr_data
);
    adc_cfg_fsm #(.CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .conv_done (conv_done),
        .tx_req    (tx_req),
        .soc       (soc),
        .cfg_main  (cfg_main),
        .cfg_win   (cfg_win),
        .win_en    (win_en)
    );

    adc_res_reg #(
        .RES_W   (RES_W),
        .RD_W    (RD_W),
        .CLR_W   (CLR_W),
        .OVR_BIT (OVR_BIT)
    ) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .rx_rd       (rx_rd),
        .clr_wr      (clr_wr),
        .clr_data    (clr_data),
        .rx_req      (rx_req),
        .rx_data     (rx_data),
        .ovr         (ovr)
    );

    // R5
    req_soc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(soc && tx_req));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (tx_req && !soc && !rx_req && !ovr));
endmodule

// File: tb/test_adc_dma_link.sv
`timescale 1ns/1ps
module test_adc_dma_link;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        rx_rd = 1'b0;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_data = '0;
    logic        tx_req, soc, win_en, rx_req, ovr;
    logic [31:0] cfg_main, cfg_win;
    logic [15:0] rx_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural reference model
    int          m_st = 0;
    logic [31:0] m_main = '0, m_win = '0;
    bit          m_wen = 0, m_unread = 0, m_ovr = 0;
    int          m_res = 0;

    always #2.5 clk = ~clk;

    adc_dma_link i_adc_dma_link (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_req(tx_req), .soc(soc), .cfg_main(cfg_main), .cfg_win(cfg_win),
        .win_en(win_en), .conv_done(conv_done), .conv_result(conv_result),
        .rx_req(rx_req), .rx_rd(rx_rd), .rx_data(rx_data), .ovr(ovr),
        .clr_wr(clr_wr), .clr_data(clr_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_main = '0; m_win = '0; m_wen = 0;
            m_unread = 0; m_ovr = 0; m_res = 0;
        end else begin
            case (m_st)
                0: if (tx_valid) begin
                       m_main = tx_data;
                       if (tx_data[31]) m_st = 1;
                       else begin m_wen = 0; m_st = 2; end
                   end
                1: if (tx_valid && !tx_data[31]) begin
                       m_win = tx_data; m_wen = 1; m_st = 2;
                   end
                2: m_st = 3;
                default: if (conv_done) m_st = 0;
            endcase
            if (conv_done && m_unread && !rx_rd) m_ovr = 1;
            else if (clr_wr && clr_data[1]) m_ovr = 0;
            if (conv_done) begin m_res = conv_result; m_unread = 1; end
            else if (rx_rd) m_unread = 0;
        end
    end

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic cmp_all();
        check("R5 tx_req", tx_req, m_st < 2);
        check("R2 soc", soc, m_st == 2);
        check("R2 cfg_main", cfg_main, m_main);
        check("R3 cfg_win", cfg_win, m_win);
        check("R3 win_en", win_en, m_wen);
        check("R7 rx_req", rx_req, m_unread);
        check("R6 rx_data", rx_data, m_res);
        check("R8 ovr", ovr, m_ovr);
    endtask

    task automatic step(bit tv, logic [31:0] td, bit dn, logic [11:0] rs,
                        bit rd, bit cw, logic [7:0] cd);
        @(negedge clk);
        cmp_all();
        tx_valid = tv; tx_data = td; conv_done = dn; conv_result = rs;
        rx_rd = rd; clr_wr = cw; clr_data = cd;
        @(posedge clk);
        #1;
        tx_valid = 0; conv_done = 0; rx_rd = 0; clr_wr = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_req", tx_req, 1);
        check("R1 soc", soc, 0);
        check("R1 rx_req", rx_req, 0);
        check("R1 ovr", ovr, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 win_en", win_en, 0);

        // R2 single word
        step(1, 32'h0000_1234, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R2 soc", soc, 1);
        check("R2 cfg_main", cfg_main, 32'h0000_1234);
        check("R2 win_en", win_en, 0);
        // R6 result arrives, ends conversion
        step(0, 0, 1, 12'hABC, 0, 0, 0);
        @(negedge clk);
        check("R6 rx_data", rx_data, 16'h0ABC);
        check("R6 rx_req", rx_req, 1);
        check("R5 tx_req back", tx_req, 1);

        // R3 main word with window marker
        step(1, 32'h8000_5555, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R3 tx_req", tx_req, 1);
        check("R3 no soc", soc, 0);
        // R4 stray marked word while waiting for window word
        step(1, 32'h8000_7777, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R4 cfg_main", cfg_main, 32'h8000_5555);
        check("R4 tx_req", tx_req, 1);
        check("R4 soc", soc, 0);
        step(1, 32'h0000_0F0F, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R3 soc", soc, 1);
        check("R3 win_en", win_en, 1);
        check("R3 cfg_win", cfg_win, 32'h0000_0F0F);
        // R5 word offered during conversion
        step(1, 32'h0000_0001, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R5 ignored", cfg_main, 32'h8000_5555);
        check("R5 tx_req low", tx_req, 0);

        // R8 overrun
        step(0, 0, 1, 12'h111, 0, 0, 0);
        @(negedge clk);
        check("R8 ovr set", ovr, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R8 ovr sticky", ovr, 1);
        // R9 clear behaviour
        step(0, 0, 0, 0, 0, 1, 8'h01);
        @(negedge clk);
        check("R9 other bit", ovr, 1);
        step(0, 0, 1, 12'h155, 0, 1, 8'h02);
        @(negedge clk);
        check("R9 set wins", ovr, 1);
        step(0, 0, 0, 0, 0, 1, 8'h02);
        @(negedge clk);
        check("R9 cleared", ovr, 0);

        // R10 read and result in same cycle
        step(0, 0, 1, 12'h222, 1, 0, 0);
        @(negedge clk);
        check("R10 ovr", ovr, 0);
        check("R10 rx_req", rx_req, 1);
        check("R10 rx_data", rx_data, 16'h0222);
        step(0, 0, 0, 0, 1, 0, 0);
        @(negedge clk);
        check("R7 rx_req", rx_req, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        @(negedge clk);
        check("R7 idle read", rx_req, 0);
        check("R7 data kept", rx_data, 16'h0222);

        // pseudo-random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] w;
            w = $urandom;
            w[31] = ($urandom % 3) == 0;
            step(($urandom % 2) == 0, w, ($urandom % 5) == 0, 12'($urandom),
                 ($urandom % 3) == 0, ($urandom % 7) == 0, 8'($urandom));
        end
        @(negedge clk);
        cmp_all();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule